// File: doc/BRIEF.md
# Fixed-Point Single-Qubit Gate Unit

This block applies one single-qubit gate to a qubit state held as four fixed-point amplitude components: the real and imaginary parts of the |0> amplitude (alpha) and of the |1> amplitude (beta). A 2-bit opcode picks the gate: Hadamard, phase shift, bit flip (X) or sign flip (Z). For the phase shift, the cosine and sine of the angle arrive as fixed-point inputs.

Every component has a sign bit, one integer bit and `FRAC` fraction bits. The result is written to an output state register, two clock cycles after the input is accepted. Because the unit is fully pipelined, it accepts a new qubit on every cycle, and several units can be chained to form a gate network.

The X and Z gates only move or flip bits. The Hadamard and phase-shift gates pass through four real multipliers, which truncate, followed by saturating adders.

Top module: `qg_gate_unit`

## Requirements
- R1: Each component is sign-magnitude with W = FRAC+2 bits. Bit W-1 is the sign (1 = negative), bit W-2 is the integer bit, and bits FRAC-1..0 are the fraction. The value is (-1)^sign * magnitude / 2^FRAC. A negative zero equals a positive zero.
- R2: The opcode is encoded as 00 = Hadamard, 01 = phase shift, 10 = X, 11 = Z. A result appears with out_valid high exactly two clock cycles after the cycle in which in_valid was high. One new input per cycle is accepted, and results leave in input order.
- R3: For Hadamard, with k = floor(2^FRAC/sqrt2) and each part computed separately for real and imaginary: alpha' = alpha*k + beta*k and beta' = alpha*k - beta*k.
- R4: For phase shift, alpha leaves exactly unchanged. Re beta' = Re(beta)*cos - Im(beta)*sin and Im beta' = Re(beta)*sin + Im(beta)*cos.
- R5: For X, the alpha and beta fields swap exactly.
- R6: For Z, the sign bits of both beta components invert, while every magnitude and all of alpha stay unchanged.
- R7: Each real product takes the sign as the XOR of the operand signs. Its magnitude is truncated toward zero to FRAC fraction bits, and saturates to the largest magnitude if it exceeds that magnitude.
- R8: A sum or difference whose magnitude exceeds 2 - 2^-FRAC saturates to that largest magnitude and keeps the sign of the true result.
- R9: After reset, out_valid is low and all four output components are zero.
- R10: While in_valid is low, the input fields have no effect. The output state holds its last result.
- R11: With FRAC = 16, Hadamard applied to alpha = beta = floor(2^16/sqrt2)/2^16 gives alpha' within 2^-13 of 1 and beta' exactly zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input qubit and opcode are present |
| in_op | input | 2 | Gate select |
| in_are | input | FRAC+2 | Alpha, real part |
| in_aim | input | FRAC+2 | Alpha, imaginary part |
| in_bre | input | FRAC+2 | Beta, real part |
| in_bim | input | FRAC+2 | Beta, imaginary part |
| ph_cos | input | FRAC+2 | Cosine of phase angle |
| ph_sin | input | FRAC+2 | Sine of phase angle |
| out_valid | output | 1 | Output state register updated |
| out_are | output | FRAC+2 | Result alpha, real part |
| out_aim | output | FRAC+2 | Result alpha, imaginary part |
| out_bre | output | FRAC+2 | Result beta, real part |
| out_bim | output | FRAC+2 | Result beta, imaginary part |

## Verification
The bench sends negative operands through the multipliers. A design that rounds instead of truncating toward zero, or that takes the wrong product sign, would be off by one in the last bit or would flip signs. Full-scale inputs to Hadamard and to the phase shift push sums past the integer bit in both directions; a design without saturation would wrap around to small or wrongly signed values. Z applied to a zero beta, and X applied to asymmetric states, catch sign-bit or field-order slips. Back-to-back streams with junk data on idle cycles expose a pipeline that drops, reorders or picks up unqualified data.

// File: rtl/qg_pkg.sv
package qg_pkg;

  typedef enum logic [1:0] {
    OP_HAD = 2'b00,
    OP_PHS = 2'b01,
    OP_SWP = 2'b10,
    OP_NEG = 2'b11
  } qg_op_e;

  // floor(sqrt(v)) by bitwise search
  function automatic longint unsigned isqrt_floor(input longint unsigned v);
    longint unsigned res;
    longint unsigned cand;
    res = 0;
    for (int i = 31; i >= 0; i--) begin
      cand = res | (64'd1 << i);
      if (cand * cand <= v) res = cand;
    end
    return res;
  endfunction

  // floor(2^frac / sqrt2) = floor(sqrt(2^(2*frac-1)))
  function automatic longint unsigned inv_root2(input int frac);
    return isqrt_floor(64'd1 << (2 * frac - 1));
  endfunction

endpackage

// File: rtl/qg_smul.sv
module qg_smul #(
  parameter int FRAC = 16,
  localparam int M = FRAC + 1,
  localparam int W = FRAC + 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p
);
  logic [2*M-1:0] full;
  logic [2*M-1:0] shifted;
  logic           ovf;
  logic [M-1:0]   mag;

  always_comb begin
    full    = a[M-1:0] * b[M-1:0];
    shifted = full >> FRAC;
    ovf     = |shifted[2*M-1:M];
    mag     = ovf ? {M{1'b1}} : shifted[M-1:0];
    p       = {(a[W-1] ^ b[W-1]) & (|mag), mag};
  end
endmodule

// File: rtl/qg_sadd.sv
module qg_sadd #(
  parameter int FRAC = 16,
  localparam int M = FRAC + 1,
  localparam int W = FRAC + 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] s
);
  logic signed [M+1:0] ta;
  logic signed [M+1:0] tb;
  logic signed [M+1:0] sum;
  logic        [M+1:0] absv;
  logic        [M-1:0] mag;

  always_comb begin
    ta   = a[W-1] ? -$signed({2'b00, a[M-1:0]}) : $signed({2'b00, a[M-1:0]});
    tb   = (b[W-1] ^ sub) ? -$signed({2'b00, b[M-1:0]}) : $signed({2'b00, b[M-1:0]});
    sum  = ta + tb;
    absv = sum[M+1] ? $unsigned(-sum) : $unsigned(sum);
    mag  = (|absv[M+1:M]) ? {M{1'b1}} : absv[M-1:0];
    s    = {sum[M+1], mag};
  end
endmodule

// File: rtl/qg_stage_mul.sv
module qg_stage_mul
  import qg_pkg::*;
#(
  parameter int FRAC = 16,
  localparam int W = FRAC + 2,
  localparam int LANES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  qg_op_e                   in_op,
  input  logic [LANES-1:0][W-1:0]  in_st,
  input  logic [W-1:0]             ph_cos,
  input  logic [W-1:0]             ph_sin,
  output logic                     s1_valid,
  output qg_op_e                   s1_op,
  output logic [LANES-1:0][W-1:0]  s1_raw,
  output logic [LANES-1:0][W-1:0]  s1_prod
);
  localparam logic [W-1:0] HCOEF = W'(inv_root2(FRAC));

  logic [LANES-1:0][W-1:0] mul_a;
  logic [LANES-1:0][W-1:0] mul_b;
  logic [LANES-1:0][W-1:0] prod_d;

  logic                    valid_n;
  qg_op_e                  op_n;
  logic [LANES-1:0][W-1:0] raw_n;
  logic [LANES-1:0][W-1:0] prod_n;

  // operand routing: lanes 0..3 = alpha re, alpha im, beta re, beta im
  always_comb begin
    mul_a = '0;
    mul_b = '0;
    case (in_op)
      OP_HAD: begin
        for (int i = 0; i < LANES; i++) begin
          mul_a[i] = in_st[i];
          mul_b[i] = HCOEF;
        end
      end
      OP_PHS: begin
        mul_a[0] = in_st[2]; mul_b[0] = ph_cos;
        mul_a[1] = in_st[3]; mul_b[1] = ph_sin;
        mul_a[2] = in_st[2]; mul_b[2] = ph_sin;
        mul_a[3] = in_st[3]; mul_b[3] = ph_cos;
      end
      default: begin
        mul_a = '0;
        mul_b = '0;
      end
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_mul
    qg_smul #(.FRAC(FRAC)) u_mul (
      .a (mul_a[g]),
      .b (mul_b[g]),
      .p (prod_d[g])
    );
  end

  always_comb begin
    valid_n = in_valid;
    op_n    = s1_op;
    raw_n   = s1_raw;
    prod_n  = s1_prod;
    if (in_valid) begin
      op_n   = in_op;
      raw_n  = in_st;
      prod_n = prod_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_op    <= OP_HAD;
      s1_raw   <= '0;
      s1_prod  <= '0;
    end else begin
      s1_valid <= valid_n;
      s1_op    <= op_n;
      s1_raw   <= raw_n;
      s1_prod  <= prod_n;
    end
  end

  // R7
  zero_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_HAD && in_st[0][W-2:0] == '0) |=> s1_prod[0][W-2:0] == '0);
endmodule

// File: rtl/qg_stage_sum.sv
module qg_stage_sum
  import qg_pkg::*;
#(
  parameter int FRAC = 16,
  localparam int W = FRAC + 2,
  localparam int LANES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s1_valid,
  input  qg_op_e                   s1_op,
  input  logic [LANES-1:0][W-1:0]  s1_raw,
  input  logic [LANES-1:0][W-1:0]  s1_prod,
  output logic                     out_valid,
  output logic [LANES-1:0][W-1:0]  out_st
);
  logic [LANES-1:0][W-1:0] add_a;
  logic [LANES-1:0][W-1:0] add_b;
  logic [LANES-1:0]        add_sub;
  logic [LANES-1:0][W-1:0] add_s;
  logic [LANES-1:0][W-1:0] res;
  logic                    valid_n;
  logic [LANES-1:0][W-1:0] st_n;

  always_comb begin
    add_a   = '0;
    add_b   = '0;
    add_sub = '0;
    case (s1_op)
      OP_HAD: begin
        add_a[0] = s1_prod[0]; add_b[0] = s1_prod[2]; add_sub[0] = 1'b0;
        add_a[1] = s1_prod[1]; add_b[1] = s1_prod[3]; add_sub[1] = 1'b0;
        add_a[2] = s1_prod[0]; add_b[2] = s1_prod[2]; add_sub[2] = 1'b1;
        add_a[3] = s1_prod[1]; add_b[3] = s1_prod[3]; add_sub[3] = 1'b1;
      end
      OP_PHS: begin
        add_a[2] = s1_prod[0]; add_b[2] = s1_prod[1]; add_sub[2] = 1'b1;
        add_a[3] = s1_prod[2]; add_b[3] = s1_prod[3]; add_sub[3] = 1'b0;
      end
      default: begin
        add_a   = '0;
        add_b   = '0;
        add_sub = '0;
      end
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_add
    qg_sadd #(.FRAC(FRAC)) u_add (
      .a   (add_a[g]),
      .b   (add_b[g]),
      .sub (add_sub[g]),
      .s   (add_s[g])
    );
  end

  always_comb begin
    case (s1_op)
      OP_HAD:  res = add_s;
      OP_PHS:  res = {add_s[3], add_s[2], s1_raw[1], s1_raw[0]};
      OP_SWP:  res = {s1_raw[1], s1_raw[0], s1_raw[3], s1_raw[2]};
      default: res = {~s1_raw[3][W-1], s1_raw[3][W-2:0],
                      ~s1_raw[2][W-1], s1_raw[2][W-2:0],
                      s1_raw[1], s1_raw[0]};
    endcase
  end

  always_comb begin
    valid_n = s1_valid;
    st_n    = out_st;
    if (s1_valid) st_n = res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_st    <= '0;
    end else begin
      out_valid <= valid_n;
      out_st    <= st_n;
    end
  end

  // R5
  swap_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_op == OP_SWP) |=>
      (out_st[0] == $past(s1_raw[2]) && out_st[1] == $past(s1_raw[3]) &&
       out_st[2] == $past(s1_raw[0]) && out_st[3] == $past(s1_raw[1])));

  // R6
  neg_beta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_op == OP_NEG) |=>
      (out_st[2][W-1] != $past(s1_raw[2][W-1]) && out_st[3][W-1] != $past(s1_raw[3][W-1]) &&
       out_st[2][W-2:0] == $past(s1_raw[2][W-2:0]) && out_st[1:0] == $past(s1_raw[1:0])));

  // R4
  phase_alpha_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_op == OP_PHS) |=> out_st[1:0] == $past(s1_raw[1:0]));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(out_st));
endmodule

// File: rtl/qg_gate_unit.sv
module qg_gate_unit
  import qg_pkg::*;
#(
  parameter int FRAC = 16,
  localparam int W = FRAC + 2,
  localparam int LANES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   in_op,
  input  logic [W-1:0] in_are,
  input  logic [W-1:0] in_aim,
  input  logic [W-1:0] in_bre,
  input  logic [W-1:0] in_bim,
  input  logic [W-1:0] ph_cos,
  input  logic [W-1:0] ph_sin,
  output logic         out_valid,
  output logic [W-1:0] out_are,
  output logic [W-1:0] out_aim,
  output logic [W-1:0] out_bre,
  output logic [W-1:0] out_bim
);
  logic [1:0]              rst_sync;
  logic                    rst_q;
  logic [LANES-1:0][W-1:0] in_st;
  logic                    s1_valid;
  qg_op_e                  s1_op;
  logic [LANES-1:0][W-1:0] s1_raw;
  logic [LANES-1:0][W-1:0] s1_prod;
  logic [LANES-1:0][W-1:0] out_st;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  assign in_st = {in_bim, in_bre, in_aim, in_are};

  qg_stage_mul #(.FRAC(FRAC)) u_mul (
    .clk      (clk),
    .rst_n    (rst_q),
    .in_valid (in_valid),
    .in_op    (qg_op_e'(in_op)),
    .in_st    (in_st),
    .ph_cos   (ph_cos),
    .ph_sin   (ph_sin),
    .s1_valid (s1_valid),
    .s1_op    (s1_op),
    .s1_raw   (s1_raw),
    .s1_prod  (s1_prod)
  );

  qg_stage_sum #(.FRAC(FRAC)) u_sum (
    .clk       (clk),
    .rst_n     (rst_q),
    .s1_valid  (s1_valid),
    .s1_op     (s1_op),
    .s1_raw    (s1_raw),
    .s1_prod   (s1_prod),
    .out_valid (out_valid),
    .out_st    (out_st)
  );

  assign out_are = out_st[0];
  assign out_aim = out_st[1];
  assign out_bre = out_st[2];
  assign out_bim = out_st[3];

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> ##1 out_valid);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> ##1 !out_valid);
endmodule

// File: tb/tb_qg_gate_unit.sv
module tb_qg_gate_unit;
  localparam int F = 16;
  localparam int W = F + 2;
  localparam longint MAXM = (64'd1 << (F + 1)) - 1;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   in_op;
  logic [W-1:0] in_are, in_aim, in_bre, in_bim, ph_cos, ph_sin;
  logic         out_valid;
  logic [W-1:0] out_are, out_aim, out_bre, out_bim;

  qg_gate_unit #(.FRAC(F)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_are(in_are), .in_aim(in_aim), .in_bre(in_bre), .in_bim(in_bim),
    .ph_cos(ph_cos), .ph_sin(ph_sin), .out_valid(out_valid),
    .out_are(out_are), .out_aim(out_aim), .out_bre(out_bre), .out_bim(out_bim)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    logic [3:0][W-1:0] exp_st;
    string             tag;
    int                stamp;
  } item_t;

  item_t             sb[$];
  int                total = 0;
  int                bad = 0;
  int                cyc = 0;
  bit                done = 0;
  logic [3:0][W-1:0] last_exp;

  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- fixed-point model from the requirements ----------------
  function automatic longint val(input logic [W-1:0] x);
    longint m;
    m = longint'(x[W-2:0]);
    return x[W-1] ? -m : m;
  endfunction

  function automatic logic [W-1:0] pack_sat(input longint v);
    longint m;
    m = (v < 0) ? -v : v;
    if (m > MAXM) m = MAXM;
    return {(v < 0), m[W-2:0]};
  endfunction

  function automatic logic [W-1:0] m_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    longint ma, mb, m;
    ma = longint'(a[W-2:0]);
    mb = longint'(b[W-2:0]);
    m  = (ma * mb) >>> F;
    if (m > MAXM) m = MAXM;
    return {(a[W-1] ^ b[W-1]) && (m != 0), m[W-2:0]};
  endfunction

  function automatic logic [W-1:0] m_add(input logic [W-1:0] a, input logic [W-1:0] b, input bit sub);
    return pack_sat(sub ? val(a) - val(b) : val(a) + val(b));
  endfunction

  function automatic logic [W-1:0] enc(input real x);
    longint m;
    real ax;
    ax = (x < 0.0) ? -x : x;
    m  = longint'($rtoi(ax * real'(64'd1 << F)));
    if (m > MAXM) m = MAXM;
    return {(x < 0.0), m[W-2:0]};
  endfunction

  function automatic bit same(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a[W-2:0] == b[W-2:0]) && ((a[W-1] == b[W-1]) || (a[W-2:0] == '0));
  endfunction

  // ---------------- driver ----------------
  task automatic send(input logic [1:0] op, input logic [W-1:0] ar, input logic [W-1:0] ai,
                      input logic [W-1:0] br, input logic [W-1:0] bi,
                      input logic [W-1:0] c, input logic [W-1:0] s, input string tag);
    item_t it;
    logic [W-1:0] k;
    k = W'($rtoi(real'(64'd1 << F) / $sqrt(2.0)));
    case (op)
      2'b00: begin
        it.exp_st[0] = m_add(m_mul(ar, k), m_mul(br, k), 1'b0);
        it.exp_st[1] = m_add(m_mul(ai, k), m_mul(bi, k), 1'b0);
        it.exp_st[2] = m_add(m_mul(ar, k), m_mul(br, k), 1'b1);
        it.exp_st[3] = m_add(m_mul(ai, k), m_mul(bi, k), 1'b1);
      end
      2'b01: begin
        it.exp_st[0] = ar;
        it.exp_st[1] = ai;
        it.exp_st[2] = m_add(m_mul(br, c), m_mul(bi, s), 1'b1);
        it.exp_st[3] = m_add(m_mul(br, s), m_mul(bi, c), 1'b0);
      end
      2'b10: it.exp_st = {ai, ar, bi, br};
      default: it.exp_st = {~bi[W-1], bi[W-2:0], ~br[W-1], br[W-2:0], ai, ar};
    endcase
    @(negedge clk);
    in_valid = 1'b1;
    in_op = op;
    in_are = ar; in_aim = ai; in_bre = br; in_bim = bi;
    ph_cos = c; ph_sin = s;
    it.tag = tag;
    it.stamp = cyc;
    last_exp = it.exp_st;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_op = 2'(i);
      in_are = W'(18'h1ABCD + i); in_aim = W'(18'h2F00F);
      in_bre = W'(18'h07777); in_bim = W'(18'h3FFFF);
      ph_cos = W'(18'h12345); ph_sin = W'(18'h0FFFF);
    end
  endtask

  // ---------------- monitor / scoreboard ----------------
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (sb.size() == 0) begin
        total++; bad++;
        $display("FAIL R2: unexpected out_valid, got 1 exp 0");
      end else begin
        item_t it;
        bit ok;
        logic [3:0][W-1:0] got;
        it = sb.pop_front();
        got = {out_bim, out_bre, out_aim, out_are};
        ok = 1'b1;
        for (int l = 0; l < 4; l++) if (!same(got[l], it.exp_st[l])) ok = 1'b0;
        total++;
        if (!ok) begin
          bad++;
          $display("FAIL %s: got %h exp %h", it.tag, got, it.exp_st);
        end
        total++;
        if (cyc - it.stamp != 2) begin
          bad++;
          $display("FAIL R2: latency got %0d exp 2", cyc - it.stamp);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [W-1:0] q, one, hmax, z0;
    real ra;
    rst_n = 1'b0;
    in_valid = 1'b0; in_op = 2'b00;
    in_are = '0; in_aim = '0; in_bre = '0; in_bim = '0; ph_cos = '0; ph_sin = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    total++;
    if (out_valid !== 1'b0 || {out_are, out_aim, out_bre, out_bim} !== '0) begin
      bad++;
      $display("FAIL R9: got valid=%b st=%h exp 0", out_valid, {out_are, out_aim, out_bre, out_bim});
    end

    one  = enc(1.0);
    q    = W'($rtoi(real'(64'd1 << F) / $sqrt(2.0)));
    hmax = W'(MAXM);
    z0   = '0;

    // R3 Hadamard, R1 format, back-to-back stream (R2)
    send(2'b00, one, z0, z0, z0, z0, z0, "R3 H on |0>");
    send(2'b00, z0, z0, one, z0, z0, z0, "R3 H on |1>");
    send(2'b00, enc(0.3), enc(-0.4), enc(-0.5), enc(0.6), z0, z0, "R3 H complex R1 signs");
    // R8 saturation both directions
    send(2'b00, hmax, {1'b1, hmax[W-2:0]}, hmax, {1'b1, hmax[W-2:0]}, z0, z0, "R8 H saturate");
    // R4 phase shift
    send(2'b01, enc(0.6), enc(-0.2), enc(0.5), enc(0.25), z0, one, "R4 phase pi/2");
    send(2'b01, enc(-0.1), enc(0.1), enc(-0.7), enc(0.3), enc(0.70710678), enc(0.70710678), "R4 phase pi/4");
    send(2'b01, z0, z0, enc(-0.3333), enc(-0.1111), enc(-0.5), enc(0.8660254), "R4 R7 negative truncation");
    send(2'b01, z0, z0, hmax, {1'b1, hmax[W-2:0]}, hmax, hmax, "R8 phase saturate");
    // R5 / R6
    send(2'b10, enc(0.8), enc(-0.1), enc(0.05), enc(-0.59), z0, z0, "R5 X swap");
    send(2'b11, enc(0.8), enc(-0.1), enc(0.05), enc(-0.59), z0, z0, "R6 Z flip");
    send(2'b11, enc(1.0), z0, z0, z0, z0, z0, "R6 Z on zero beta");
    // R7 product magnitudes below one LSB truncate to zero
    send(2'b01, enc(0.5), z0, W'(1), {1'b1, 17'd1}, W'(1), W'(1), "R7 tiny product");
    idle(5);

    // R10 idle inputs ignored, state held
    total++;
    if (out_valid !== 1'b0 || {out_bim, out_bre, out_aim, out_are} !== last_exp) begin
      bad++;
      $display("FAIL R10: got %h exp %h", {out_bim, out_bre, out_aim, out_are}, last_exp);
    end

    // R11 precision of Hadamard on equal superposition
    send(2'b00, q, z0, q, z0, z0, z0, "R11 H superposition");
    idle(4);
    ra = real'(val(out_are)) / real'(64'd1 << F);
    total++;
    if ((ra - 1.0 > 1.0 / 8192.0) || (1.0 - ra > 1.0 / 8192.0) || out_bre[W-2:0] != '0
        || out_aim[W-2:0] != '0 || out_bim[W-2:0] != '0) begin
      bad++;
      $display("FAIL R11: got alpha=%f beta=%h exp alpha~1.0 beta 0", ra, out_bre);
    end

    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R2: %0d results missing, exp 0", sb.size());
    end
    finish_run();
  end
endmodule